// File: doc/BRIEF.md
# Interrupt System-Register Access Trap Decoder

This block decides, for one access to a system register of the interrupt CPU interface, whether the access goes ahead, is taken to the highest exception level (EL3), or raises an ordinary undefined-instruction trap. It is pure combinational logic. The register file that holds the interface state sits next to it, and that register file acts on the 2-bit result code in the same cycle.

Every register belongs to an interrupt class: fast-interrupt, normal-interrupt, or both. The checks apply only when the secure configuration routes the matching interrupt kind to EL3. In that case the decision depends on the current exception level, the security state, the hypervisor virtualisation bits and the monitor-mode state. If EL3 itself runs in the 32-bit execution state, a trap to EL3 is turned into a plain trap.

Top module: `irq_sysreg_trap`

## Requirements
- R1: With class code 0 (fast-interrupt class) and `scr_fiq_route_i` low, the result is 0 (proceed) whatever the other inputs are.
- R2: With class code 1 (normal-interrupt class) and `scr_irq_route_i` low, the result is 0 whatever the other inputs are.
- R3: With class code 2 (both classes), the checks apply only when both routing bits are high. If either bit is low, the result is 0.
- R4: For a checked access at EL1 (level code 1) with `secure_below_el3_i` high, the result is a trap to EL3.
- R5: For a checked non-secure access at EL1, the access traps to EL3 when the matching hypervisor bit is low. That bit is `hyp_fmo_i` for class 0 and `hyp_imo_i` for class 1. For class 2 the access traps only when both bits are low. Otherwise the result is 0.
- R6: A checked access at EL2 (level code 2) always traps to EL3.
- R7: A checked access at EL3 (level code 3) traps to EL3 only when `cur_aa64_i` is low and `monitor_mode_i` is low. Otherwise the result is 0.
- R8: Result codes are 0 for proceed, 1 for trap to EL3 and 2 for plain trap. A trap to EL3 is reported as code 2 when `el3_aa64_i` is low and as code 1 when it is high.
- R9: An access at EL0 (level code 0) always gives result 0.
- R10: Class code 3 behaves exactly like class code 2, and the result is never code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_class_i | input | 2 | Register class: 0 fast-interrupt, 1 normal-interrupt, 2 or 3 both |
| cur_el_i | input | 2 | Current exception level, 0 to 3 |
| secure_below_el3_i | input | 1 | Processor is in the secure state below EL3 |
| cur_aa64_i | input | 1 | Current level runs in the 64-bit execution state |
| el3_aa64_i | input | 1 | EL3 runs in the 64-bit execution state |
| monitor_mode_i | input | 1 | Processor is in monitor mode |
| scr_fiq_route_i | input | 1 | Secure configuration routes fast interrupts to EL3 |
| scr_irq_route_i | input | 1 | Secure configuration routes normal interrupts to EL3 |
| hyp_imo_i | input | 1 | Hypervisor virtualises normal interrupts |
| hyp_fmo_i | input | 1 | Hypervisor virtualises fast interrupts |
| result_o | output | 2 | Decision: 0 proceed, 1 trap to EL3, 2 plain trap |

## Verification
The result has no register on its path, so it is due in the same cycle its inputs settle, zero clock edges after the stimulus. The bench drives a new input vector just after a falling clock edge. It waits one nanosecond and then compares `result_o` with a value that the bench works out from the requirements, well before the next rising edge. The bench sweeps all 4096 combinations of class, level and the eight flag inputs, and tags each mismatch with the requirement that decides that case.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
  localparam int unsigned ClassW = 2;
  localparam int unsigned ElW    = 2;
  localparam int unsigned ResW   = 2;

  typedef enum logic [ClassW-1:0] {
    CLS_FIQ  = 2'd0,
    CLS_IRQ  = 2'd1,
    CLS_BOTH = 2'd2,
    CLS_RSVD = 2'd3
  } reg_class_e;

  typedef enum logic [ResW-1:0] {
    RES_OK       = 2'd0,
    RES_TRAP_EL3 = 2'd1,
    RES_TRAP     = 2'd2
  } trap_res_e;

  localparam logic [ElW-1:0] EL0 = 2'd0;
  localparam logic [ElW-1:0] EL1 = 2'd1;
  localparam logic [ElW-1:0] EL2 = 2'd2;
  localparam logic [ElW-1:0] EL3 = 2'd3;
endpackage

// File: rtl/irq_trap_route_gate.sv
module irq_trap_route_gate
  import irq_trap_pkg::*;
(
  input  logic [ClassW-1:0] reg_class_i,
  input  logic              scr_fiq_route_i,
  input  logic              scr_irq_route_i,
  output logic              uses_fiq_o,
  output logic              uses_irq_o,
  output logic              checked_o
);
  always_comb begin
    uses_fiq_o = 1'b0;
    uses_irq_o = 1'b0;
    unique case (reg_class_e'(reg_class_i))
      CLS_FIQ: uses_fiq_o = 1'b1;
      CLS_IRQ: uses_irq_o = 1'b1;
      default: begin  // both, and reserved code aliased to both
        uses_fiq_o = 1'b1;
        uses_irq_o = 1'b1;
      end
    endcase
  end

  // every routing bit the class depends on must be set
  assign checked_o = (~uses_fiq_o | scr_fiq_route_i) & (~uses_irq_o | scr_irq_route_i);
endmodule

// File: rtl/irq_trap_level_eval.sv
module irq_trap_level_eval
  import irq_trap_pkg::*;
(
  input  logic [ElW-1:0] cur_el_i,
  input  logic           checked_i,
  input  logic           uses_fiq_i,
  input  logic           uses_irq_i,
  input  logic           secure_below_el3_i,
  input  logic           cur_aa64_i,
  input  logic           monitor_mode_i,
  input  logic           hyp_imo_i,
  input  logic           hyp_fmo_i,
  output logic           want_el3_o
);
  logic virt_off;

  // hypervisor bits that matter for this class; all of them clear means no virtualisation
  assign virt_off = ~((uses_fiq_i & hyp_fmo_i) | (uses_irq_i & hyp_imo_i));

  always_comb begin
    want_el3_o = 1'b0;
    if (checked_i) begin
      unique case (cur_el_i)
        EL1:     want_el3_o = secure_below_el3_i | virt_off;
        EL2:     want_el3_o = 1'b1;
        EL3:     want_el3_o = ~cur_aa64_i & ~monitor_mode_i;
        default: want_el3_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_trap_encode.sv
module irq_trap_encode
  import irq_trap_pkg::*;
(
  input  logic            want_el3_i,
  input  logic            el3_aa64_i,
  output logic [ResW-1:0] result_o
);
  trap_res_e res;

  always_comb begin
    if (!want_el3_i)      res = RES_OK;
    else if (el3_aa64_i)  res = RES_TRAP_EL3;
    else                  res = RES_TRAP;  // EL3 in 32-bit state cannot take the routed trap
  end

  assign result_o = res;
endmodule

// File: rtl/irq_sysreg_trap.sv
module irq_sysreg_trap
  import irq_trap_pkg::*;
(
  input  logic [1:0] reg_class_i,
  input  logic [1:0] cur_el_i,
  input  logic       secure_below_el3_i,
  input  logic       cur_aa64_i,
  input  logic       el3_aa64_i,
  input  logic       monitor_mode_i,
  input  logic       scr_fiq_route_i,
  input  logic       scr_irq_route_i,
  input  logic       hyp_imo_i,
  input  logic       hyp_fmo_i,
  output logic [1:0] result_o
);
  logic uses_fiq, uses_irq, checked, want_el3;

  irq_trap_route_gate u_gate (
    .reg_class_i     (reg_class_i),
    .scr_fiq_route_i (scr_fiq_route_i),
    .scr_irq_route_i (scr_irq_route_i),
    .uses_fiq_o      (uses_fiq),
    .uses_irq_o      (uses_irq),
    .checked_o       (checked)
  );

  irq_trap_level_eval u_level (
    .cur_el_i           (cur_el_i),
    .checked_i          (checked),
    .uses_fiq_i         (uses_fiq),
    .uses_irq_i         (uses_irq),
    .secure_below_el3_i (secure_below_el3_i),
    .cur_aa64_i         (cur_aa64_i),
    .monitor_mode_i     (monitor_mode_i),
    .hyp_imo_i          (hyp_imo_i),
    .hyp_fmo_i          (hyp_fmo_i),
    .want_el3_o         (want_el3)
  );

  irq_trap_encode u_enc (
    .want_el3_i (want_el3),
    .el3_aa64_i (el3_aa64_i),
    .result_o   (result_o)
  );
endmodule

// File: rtl/irq_sysreg_trap_chk.sv
module irq_sysreg_trap_chk (
  input logic [1:0] reg_class_i,
  input logic [1:0] cur_el_i,
  input logic       secure_below_el3_i,
  input logic       cur_aa64_i,
  input logic       el3_aa64_i,
  input logic       monitor_mode_i,
  input logic       scr_fiq_route_i,
  input logic       scr_irq_route_i,
  input logic       want_el3,
  input logic       checked,
  input logic [1:0] result_o
);
  always_comb begin
    AST_FIQ_UNROUTED_OK: assert (!(reg_class_i == 2'd0 && !scr_fiq_route_i) || result_o == 2'd0); // R1
    AST_IRQ_UNROUTED_OK: assert (!(reg_class_i == 2'd1 && !scr_irq_route_i) || result_o == 2'd0); // R2
    AST_BOTH_NEEDS_TWO:  assert (!(reg_class_i[1] && !(scr_fiq_route_i && scr_irq_route_i)) || result_o == 2'd0); // R3
    AST_EL1_SECURE_TRAP: assert (!(checked && cur_el_i == 2'd1 && secure_below_el3_i) || result_o != 2'd0); // R4
    AST_EL2_ALWAYS_TRAP: assert (!(checked && cur_el_i == 2'd2) || result_o != 2'd0); // R6
    AST_EL3_MON_OK:      assert (!(cur_el_i == 2'd3 && (cur_aa64_i || monitor_mode_i)) || result_o == 2'd0); // R7
    AST_DEMOTE_STATE:    assert (!want_el3 || result_o == (el3_aa64_i ? 2'd1 : 2'd2)); // R8
    AST_EL0_OK:          assert (cur_el_i != 2'd0 || result_o == 2'd0); // R9
    AST_NO_CODE3:        assert (result_o != 2'd3); // R10
  end
endmodule

bind irq_sysreg_trap irq_sysreg_trap_chk u_chk (
  .reg_class_i        (reg_class_i),
  .cur_el_i           (cur_el_i),
  .secure_below_el3_i (secure_below_el3_i),
  .cur_aa64_i         (cur_aa64_i),
  .el3_aa64_i         (el3_aa64_i),
  .monitor_mode_i     (monitor_mode_i),
  .scr_fiq_route_i    (scr_fiq_route_i),
  .scr_irq_route_i    (scr_irq_route_i),
  .want_el3           (want_el3),
  .checked            (checked),
  .result_o           (result_o)
);

// File: tb/irq_sysreg_trap_tb_top.sv
`timescale 1ns/1ps
module irq_sysreg_trap_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] cls, el;
  logic sec, c64, e64, mon, sfiq, sirq, imo, fmo;
  logic [1:0] res;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit done = 1'b0;

  irq_sysreg_trap dut_i (
    .reg_class_i        (cls),
    .cur_el_i           (el),
    .secure_below_el3_i (sec),
    .cur_aa64_i         (c64),
    .el3_aa64_i         (e64),
    .monitor_mode_i     (mon),
    .scr_fiq_route_i    (sfiq),
    .scr_irq_route_i    (sirq),
    .hyp_imo_i          (imo),
    .hyp_fmo_i          (fmo),
    .result_o           (res)
  );

  task automatic check(input logic [1:0] exp, input string tag);
    n_chk++;
    if (res !== exp) begin
      n_err++;
      $display("FAIL %s cls=%0d el=%0d flags=%b: got %0d expected %0d",
               tag, cls, el, {sec, c64, e64, mon, sfiq, sirq, imo, fmo}, res, exp);
    end
  endtask

  initial begin
    {cls, el, sec, c64, e64, mon, sfiq, sirq, imo, fmo} = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(2'd0, "R9 idle");
    for (int v = 0; v < 4096; v++) begin
      int f_cls, f_el;
      bit need_f, need_i, route, hvbit, trap;
      string tag;
      @(negedge clk);
      {cls, el, sec, c64, e64, mon, sfiq, sirq, imo, fmo} = 12'(v);
      f_cls = int'(cls);
      f_el  = int'(el);
      need_f = (f_cls != 1);
      need_i = (f_cls != 0);
      route = (!need_f || sfiq) && (!need_i || sirq);
      if (f_cls == 3) tag = "R10";
      else if (f_cls == 2) tag = "R3";
      else if (f_cls == 1) tag = "R2";
      else tag = "R1";
      trap = 1'b0;
      if (f_el == 0) begin
        tag = "R9";
      end else if (route) begin
        case (f_el)
          1: begin
            if (f_cls == 0) hvbit = fmo;
            else if (f_cls == 1) hvbit = imo;
            else hvbit = imo || fmo;
            trap = sec || !hvbit;
            tag = sec ? "R4" : "R5";
          end
          2: begin trap = 1'b1; tag = "R6"; end
          default: begin trap = !c64 && !mon; tag = "R7"; end
        endcase
      end
      #1;
      if (!trap) check(2'd0, tag);
      else if (e64) check(2'd1, tag);
      else check(2'd2, {tag, "/R8"});
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule